// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block is the digital feedback divider of a fractional-N frequency synthesizer. It runs on the oscillator clock and produces one feedback pulse per division cycle. Each cycle is built from three parts. A dual-modulus prescaler divides by P or P+1. A program counter sets how many prescaler periods make up the cycle. A swallow counter sets how many of those periods use the wide modulus. Together they give an integer ratio of P·B + A input clocks.

A fractional accumulator steps once per division cycle. Its modulus is not a power of two: it is 1920 or 1968, picked by the reference-select input. Each time the accumulator overflows, the next cycle is lengthened by one input clock. The average ratio is therefore P·B + A + FN/M. With a 19.2 MHz or 19.68 MHz reference, this yields 10 kHz channel steps.

Settings arrive on parallel inputs. They are checked and taken only at a division-cycle boundary. An illegal set is refused: the previous legal set stays in force and the error flag is raised.

Top module: `fnd_divider`

## Requirements
- R1: With the 8/9 prescaler (psc_narrow_i = 0) and a zero numerator, every division cycle lasts 8·B + A input clocks.
- R2: With psc_narrow_i = 1 the prescaler runs 6/7, and a cycle lasts 6·B + A + c clocks, where c is the overflow bit of the accumulator for that cycle.
- R3: The accumulator starts at zero. At each boundary it adds FN. When the sum reaches the modulus (1920 for ref_high_i = 0), the modulus is subtracted and the new cycle gains one clock (c = 1). Otherwise the sum is kept and c = 0.
- R4: With ref_high_i = 1 the modulus is 1968. When a boundary loads a modulus different from the active one, the accumulator restarts from zero before adding FN.
- R5: A set with A ≥ B is refused at the boundary. cfg_err_o goes high from that boundary, and the previous legal set keeps governing the cycle length. A later legal set clears cfg_err_o and takes effect.
- R6: A set is also refused when B < 2, when FN is not below the selected modulus, or when A > 5 with the 6/7 prescaler. Refusal has the same outcome as in R5.
- R7: Input changes made in the middle of a division cycle do not change that cycle's length. They take effect only from the next boundary.
- R8: fb_pulse_o is high for exactly one input clock per division cycle. It rises in the clock after the program counter's terminal count.
- R9: modulus_ctl_o is high during the first A + c prescaler periods of each cycle and low for the rest. It is therefore high for (A + c)·(P+1) clocks per cycle, including the case A + c = B, where every period is wide.
- R10: Synchronous reset clears the accumulator and drives all outputs low. It installs B = 2, A = 0, FN = 0, the 8/9 prescaler and the 1920 modulus, so the first pulse comes 16 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator (divider input) clock |
| rst | input | 1 | Synchronous reset, active high |
| prog_cnt_i | input | 4 | Program counter value B |
| swallow_i | input | 3 | Swallow count A |
| frac_num_i | input | 11 | Fractional numerator FN |
| psc_narrow_i | input | 1 | 0: 8/9 prescaler, 1: 6/7 prescaler |
| ref_high_i | input | 1 | 0: modulus 1920, 1: modulus 1968 |
| fb_pulse_o | output | 1 | One-clock feedback pulse per division cycle |
| modulus_ctl_o | output | 1 | High while the prescaler runs at P+1 |
| cfg_err_o | output | 1 | Last boundary refused the applied settings |

## Verification
At a division-cycle boundary, loading a new setting and applying an accumulator overflow happen in the same clock. The carry then lands on the swallow count that was just loaded. Directed runs place a new B, A, FN, prescaler and modulus at the boundary where the accumulator overflows. One case sets A = B − 1 with a large numerator, so that a carry turns every prescaler period wide. Another case switches the modulus mid-sequence, so that the restart and the add coincide. Each cycle is judged by its measured length and its wide-period clock count, compared against a bench model of the accumulator stepped once per observed pulse.

// File: rtl/fnd_pkg.sv
package fnd_pkg;

   typedef enum logic {
      PSC_WIDE   = 1'b0,
      PSC_NARROW = 1'b1
   } psc_mode_e;

   typedef enum logic {
      REF_LOW  = 1'b0,
      REF_HIGH = 1'b1
   } ref_mode_e;

endpackage

// File: rtl/fnd_cfg_shadow.sv
module fnd_cfg_shadow
   import fnd_pkg::*;
#(
   parameter int unsigned B_W      = 4,
   parameter int unsigned A_W      = 3,
   parameter int unsigned FN_W     = 11,
   parameter int unsigned P_WIDE   = 8,
   parameter int unsigned P_NARROW = 6,
   parameter int unsigned M_LOW    = 1920,
   parameter int unsigned M_HIGH   = 1968,
   parameter int unsigned DEF_B    = 2,
   parameter int unsigned DEF_A    = 0
)(
   input  logic            clk,
   input  logic            rst,
   input  logic            load,
   input  logic [B_W-1:0]  in_b,
   input  logic [A_W-1:0]  in_a,
   input  logic [FN_W-1:0] in_fn,
   input  logic            in_psc,
   input  logic            in_ref,
   output logic [B_W-1:0]  act_b,
   output logic [A_W-1:0]  act_a,
   output logic            act_psc,
   output logic            act_ref,
   output logic [B_W-1:0]  nxt_b,
   output logic [A_W-1:0]  nxt_a,
   output logic [FN_W-1:0] nxt_fn,
   output logic            nxt_psc,
   output logic            nxt_ref,
   output logic            cfg_err
);
   localparam logic [B_W-1:0]  B_FLOOR      = B_W'(2);
   localparam logic [A_W-1:0]  A_TOP_WIDE   = A_W'(P_WIDE - 1);
   localparam logic [A_W-1:0]  A_TOP_NARROW = A_W'(P_NARROW - 1);
   localparam logic [FN_W-1:0] MOD_LOW_V    = FN_W'(M_LOW);
   localparam logic [FN_W-1:0] MOD_HIGH_V   = FN_W'(M_HIGH);

   logic [B_W-1:0]  b_q;
   logic [A_W-1:0]  a_q;
   logic [FN_W-1:0] fn_q;
   psc_mode_e       psc_q;
   ref_mode_e       ref_q;
   psc_mode_e       in_mode;
   ref_mode_e       in_refm;
   logic [A_W-1:0]  a_top;
   logic [FN_W-1:0] fn_limit;
   logic            legal;

   // legality of the applied set, judged against its own prescaler and modulus
   always_comb begin
      in_mode  = psc_mode_e'(in_psc);
      in_refm  = ref_mode_e'(in_ref);
      a_top    = (in_mode == PSC_NARROW) ? A_TOP_NARROW : A_TOP_WIDE;
      fn_limit = (in_refm == REF_HIGH) ? MOD_HIGH_V : MOD_LOW_V;
      legal    = (in_b >= B_FLOOR) && (B_W'(in_a) < in_b) &&
                 (in_a <= a_top) && (in_fn < fn_limit);
   end

   assign nxt_b   = legal ? in_b  : b_q;
   assign nxt_a   = legal ? in_a  : a_q;
   assign nxt_fn  = legal ? in_fn : fn_q;
   assign nxt_psc = legal ? in_psc : logic'(psc_q);
   assign nxt_ref = legal ? in_ref : logic'(ref_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         b_q     <= B_W'(DEF_B);
         a_q     <= A_W'(DEF_A);
         fn_q    <= '0;
         psc_q   <= PSC_WIDE;
         ref_q   <= REF_LOW;
         cfg_err <= 1'b0;
      end else if (load) begin
         b_q     <= nxt_b;
         a_q     <= nxt_a;
         fn_q    <= nxt_fn;
         psc_q   <= psc_mode_e'(nxt_psc);
         ref_q   <= ref_mode_e'(nxt_ref);
         cfg_err <= ~legal;
      end
   end

   assign act_b   = b_q;
   assign act_a   = a_q;
   assign act_psc = logic'(psc_q);
   assign act_ref = logic'(ref_q);

endmodule

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc #(
   parameter int unsigned FN_W   = 11,
   parameter int unsigned M_LOW  = 1920,
   parameter int unsigned M_HIGH = 1968
)(
   input  logic            clk,
   input  logic            rst,
   input  logic            step,
   input  logic [FN_W-1:0] fn_nxt,
   input  logic            ref_nxt,
   input  logic            ref_act,
   output logic            carry_nxt,
   output logic [FN_W-1:0] acc_o
);
   localparam int unsigned SUM_W   = FN_W + 1;
   localparam logic [SUM_W-1:0] ML = SUM_W'(M_LOW);
   localparam logic [SUM_W-1:0] MH = SUM_W'(M_HIGH);

   logic [FN_W-1:0]  acc_q;
   logic [FN_W-1:0]  acc_nxt;
   logic [FN_W-1:0]  base;
   logic [SUM_W-1:0] sum;
   logic [SUM_W-1:0] m_sel;
   logic             restart;

   generate
      if (M_LOW == M_HIGH) begin : g_single_mod
         assign m_sel   = ML;
         assign restart = 1'b0;
      end else begin : g_dual_mod
         assign m_sel   = ref_nxt ? MH : ML;
         assign restart = (ref_nxt != ref_act);
      end
   endgenerate

   always_comb begin
      base      = restart ? '0 : acc_q;
      sum       = {1'b0, base} + {1'b0, fn_nxt};
      carry_nxt = (sum >= m_sel);
      acc_nxt   = FN_W'(carry_nxt ? (sum - m_sel) : sum);
   end

   always_ff @(posedge clk) begin
      if (rst)       acc_q <= '0;
      else if (step) acc_q <= acc_nxt;
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/fnd_prescaler.sv
module fnd_prescaler #(
   parameter int unsigned P_WIDE   = 8,
   parameter int unsigned P_NARROW = 6,
   parameter int unsigned CNT_W    = 4,
   parameter int unsigned RST_CNT  = 7
)(
   input  logic clk,
   input  logic rst,
   input  logic narrow,
   input  logic hi_nxt,
   output logic tc
);
   localparam logic [CNT_W-1:0] RL_WIDE_HI   = CNT_W'(P_WIDE);
   localparam logic [CNT_W-1:0] RL_WIDE_LO   = CNT_W'(P_WIDE - 1);
   localparam logic [CNT_W-1:0] RL_NARROW_HI = CNT_W'(P_NARROW);
   localparam logic [CNT_W-1:0] RL_NARROW_LO = CNT_W'(P_NARROW - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload;

   generate
      if (P_WIDE == P_NARROW) begin : g_one_base
         assign reload = hi_nxt ? RL_WIDE_HI : RL_WIDE_LO;
      end else begin : g_two_base
         always_comb begin
            if (narrow) reload = hi_nxt ? RL_NARROW_HI : RL_NARROW_LO;
            else        reload = hi_nxt ? RL_WIDE_HI : RL_WIDE_LO;
         end
      end
   endgenerate

   assign tc = (cnt_q == '0);

   always_ff @(posedge clk) begin
      if (rst)     cnt_q <= CNT_W'(RST_CNT);
      else if (tc) cnt_q <= reload;
      else         cnt_q <= cnt_q - CNT_W'(1);
   end

endmodule

// File: rtl/fnd_swallow_prog.sv
module fnd_swallow_prog #(
   parameter int unsigned B_W   = 4,
   parameter int unsigned A_W   = 3,
   parameter int unsigned SW_W  = 4,
   parameter int unsigned DEF_B = 2,
   parameter int unsigned DEF_A = 0
)(
   input  logic           clk,
   input  logic           rst,
   input  logic           pre_tc,
   input  logic [B_W-1:0] b_nxt,
   input  logic [A_W-1:0] a_nxt,
   input  logic           carry_nxt,
   output logic           boundary,
   output logic           hi_nxt,
   output logic           mod_ctl
);
   logic [B_W-1:0]  pc_q;
   logic [SW_W-1:0] swl_q;
   logic [SW_W-1:0] swl_load;
   logic [SW_W-1:0] swl_dec;
   logic            pc_last;

   always_comb begin
      swl_load = SW_W'(a_nxt) + SW_W'(carry_nxt);
      swl_dec  = (swl_q != '0) ? (swl_q - SW_W'(1)) : swl_q;
      pc_last  = (pc_q == B_W'(1));
      boundary = pre_tc && pc_last;
      hi_nxt   = pc_last ? (swl_load != '0) : (swl_dec != '0);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q  <= B_W'(DEF_B);
         swl_q <= SW_W'(DEF_A);
      end else if (pre_tc) begin
         if (pc_last) begin
            pc_q  <= b_nxt;
            swl_q <= swl_load;
         end else begin
            pc_q  <= pc_q - B_W'(1);
            swl_q <= swl_dec;
         end
      end
   end

   assign mod_ctl = (swl_q != '0);

endmodule

// File: rtl/fnd_divider.sv
module fnd_divider #(
   parameter int unsigned B_W      = 4,
   parameter int unsigned A_W      = 3,
   parameter int unsigned FN_W     = 11,
   parameter int unsigned P_WIDE   = 8,
   parameter int unsigned P_NARROW = 6,
   parameter int unsigned M_LOW    = 1920,
   parameter int unsigned M_HIGH   = 1968,
   parameter int unsigned DEF_B    = 2,
   parameter int unsigned DEF_A    = 0
)(
   input  logic            clk,
   input  logic            rst,
   input  logic [B_W-1:0]  prog_cnt_i,
   input  logic [A_W-1:0]  swallow_i,
   input  logic [FN_W-1:0] frac_num_i,
   input  logic            psc_narrow_i,
   input  logic            ref_high_i,
   output logic            fb_pulse_o,
   output logic            modulus_ctl_o,
   output logic            cfg_err_o
);
   localparam int unsigned CNT_W   = $clog2(P_WIDE + 1);
   localparam int unsigned SW_W    = $clog2((1 << A_W) + 1);
   localparam int unsigned RST_CNT = (DEF_A != 0) ? P_WIDE : P_WIDE - 1;

   // elaboration-time parameter checks
   generate
      if (A_W > B_W) begin : g_bad_aw
         $error("swallow width exceeds program width");
      end
      if (P_NARROW < 2 || P_NARROW > P_WIDE) begin : g_bad_p
         $error("prescaler bases out of order");
      end
      if (P_WIDE > (1 << A_W)) begin : g_bad_atop
         $error("swallow field cannot hold P-1");
      end
      if (M_LOW >= (1 << FN_W) || M_HIGH >= (1 << FN_W)) begin : g_bad_mod
         $error("modulus does not fit numerator width");
      end
      if (DEF_B < 2 || DEF_A >= DEF_B) begin : g_bad_def
         $error("illegal reset configuration");
      end
   endgenerate

   logic [B_W-1:0]  act_b, nxt_b;
   logic [A_W-1:0]  act_a, nxt_a;
   logic [FN_W-1:0] nxt_fn;
   logic            act_psc, nxt_psc, act_ref, nxt_ref;
   logic            boundary, pre_tc, hi_nxt, carry_nxt, psc_use;
   logic [FN_W-1:0] acc_q;
   logic            fb_q;

   fnd_cfg_shadow #(
      .B_W(B_W), .A_W(A_W), .FN_W(FN_W), .P_WIDE(P_WIDE), .P_NARROW(P_NARROW),
      .M_LOW(M_LOW), .M_HIGH(M_HIGH), .DEF_B(DEF_B), .DEF_A(DEF_A)
   ) u_shadow (
      .clk(clk), .rst(rst), .load(boundary),
      .in_b(prog_cnt_i), .in_a(swallow_i), .in_fn(frac_num_i),
      .in_psc(psc_narrow_i), .in_ref(ref_high_i),
      .act_b(act_b), .act_a(act_a), .act_psc(act_psc), .act_ref(act_ref),
      .nxt_b(nxt_b), .nxt_a(nxt_a), .nxt_fn(nxt_fn),
      .nxt_psc(nxt_psc), .nxt_ref(nxt_ref), .cfg_err(cfg_err_o)
   );

   fnd_frac_acc #(
      .FN_W(FN_W), .M_LOW(M_LOW), .M_HIGH(M_HIGH)
   ) u_acc (
      .clk(clk), .rst(rst), .step(boundary), .fn_nxt(nxt_fn),
      .ref_nxt(nxt_ref), .ref_act(act_ref), .carry_nxt(carry_nxt), .acc_o(acc_q)
   );

   // the prescaler reload at a boundary belongs to the incoming cycle
   assign psc_use = boundary ? nxt_psc : act_psc;

   fnd_prescaler #(
      .P_WIDE(P_WIDE), .P_NARROW(P_NARROW), .CNT_W(CNT_W), .RST_CNT(RST_CNT)
   ) u_psc (
      .clk(clk), .rst(rst), .narrow(psc_use), .hi_nxt(hi_nxt), .tc(pre_tc)
   );

   fnd_swallow_prog #(
      .B_W(B_W), .A_W(A_W), .SW_W(SW_W), .DEF_B(DEF_B), .DEF_A(DEF_A)
   ) u_cnt (
      .clk(clk), .rst(rst), .pre_tc(pre_tc), .b_nxt(nxt_b), .a_nxt(nxt_a),
      .carry_nxt(carry_nxt), .boundary(boundary), .hi_nxt(hi_nxt),
      .mod_ctl(modulus_ctl_o)
   );

   always_ff @(posedge clk) begin
      if (rst) fb_q <= 1'b0;
      else     fb_q <= boundary;
   end

   assign fb_pulse_o = fb_q;

endmodule

// File: rtl/fnd_divider_chk.sv
module fnd_divider_chk #(
   parameter int unsigned B_W    = 4,
   parameter int unsigned A_W    = 3,
   parameter int unsigned FN_W   = 11,
   parameter int unsigned M_LOW  = 1920,
   parameter int unsigned M_HIGH = 1968
)(
   input logic            clk,
   input logic            rst,
   input logic            fb_pulse,
   input logic            mod_ctl,
   input logic            cfg_err,
   input logic [B_W-1:0]  act_b,
   input logic [A_W-1:0]  act_a,
   input logic            act_ref,
   input logic [FN_W-1:0] acc_val
);
   localparam logic [FN_W-1:0] ML = FN_W'(M_LOW);
   localparam logic [FN_W-1:0] MH = FN_W'(M_HIGH);
   localparam logic [B_W-1:0]  B2 = B_W'(2);

   // R8: feedback pulse lasts a single clock
   a_r8_pulse_single: assert property (@(posedge clk) disable iff (rst)
      fb_pulse |=> !fb_pulse);

   // R7: active settings move only together with a feedback pulse
   a_r7_cfg_at_boundary: assert property (@(posedge clk) disable iff (rst)
      !$stable({act_b, act_a, act_ref}) |-> fb_pulse);

   // R5: the error flag changes only at a boundary
   a_r5_err_at_boundary: assert property (@(posedge clk) disable iff (rst)
      !$stable(cfg_err) |-> fb_pulse);

   // R5: the configuration in force is always legal
   a_r5_active_legal: assert property (@(posedge clk) disable iff (rst)
      (act_b >= B2) && (B_W'(act_a) < act_b));

   // R9: wide-modulus phase only begins at the start of a cycle
   a_r9_modctl_start: assert property (@(posedge clk) disable iff (rst)
      $rose(mod_ctl) |-> fb_pulse);

   // R3: accumulator residue stays below the modulus in force
   a_r3_acc_below_mod: assert property (@(posedge clk) disable iff (rst)
      acc_val < (act_ref ? MH : ML));

endmodule

bind fnd_divider fnd_divider_chk #(
   .B_W(B_W), .A_W(A_W), .FN_W(FN_W), .M_LOW(M_LOW), .M_HIGH(M_HIGH)
) chk_i (
   .clk(clk), .rst(rst), .fb_pulse(fb_pulse_o), .mod_ctl(modulus_ctl_o),
   .cfg_err(cfg_err_o), .act_b(act_b), .act_a(act_a), .act_ref(act_ref),
   .acc_val(acc_q)
);

// File: tb/fnd_divider_tb_top.sv
module fnd_divider_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  d_b = 4'd11;
   logic [2:0]  d_a = 3'd4;
   logic [10:0] d_fn = 11'd0;
   logic        d_psc = 1'b0;
   logic        d_ref = 1'b0;
   logic        fb_pulse, mod_ctl, cfg_err;

   int n_chk = 0;
   int n_bad = 0;

   // bench model state
   int m_b, m_a, m_fn, m_acc, exp_len, exp_hi;
   bit m_narrow, m_refh, m_err;
   // pending mid-cycle settings
   int p_b, p_a, p_fn;
   bit p_psc, p_ref;

   always #5 clk = ~clk;

   fnd_divider dut_i (
      .clk(clk), .rst(rst), .prog_cnt_i(d_b), .swallow_i(d_a), .frac_num_i(d_fn),
      .psc_narrow_i(d_psc), .ref_high_i(d_ref), .fb_pulse_o(fb_pulse),
      .modulus_ctl_o(mod_ctl), .cfg_err_o(cfg_err)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic set_cfg(input int b, input int a, input int fn, input bit psc, input bit rf);
      d_b = 4'(b); d_a = 3'(a); d_fn = 11'(fn); d_psc = psc; d_ref = rf;
   endtask

   task automatic mdl_reset();
      m_b = 2; m_a = 0; m_fn = 0; m_narrow = 0; m_refh = 0; m_acc = 0; m_err = 0;
   endtask

   // called at the negedge where a pulse is seen: the boundary just happened
   task automatic mdl_boundary(input string req);
      int amax, mlim, base, sum, carry, p, mmod;
      bit legal, restart;
      amax = d_psc ? 5 : 7;
      mlim = d_ref ? 1968 : 1920;
      legal = (d_b >= 2) && (d_a < d_b) && (d_a <= amax) && (d_fn < mlim);
      restart = 0;
      if (legal) begin
         restart = (d_ref != m_refh);
         m_b = d_b; m_a = d_a; m_fn = d_fn; m_narrow = d_psc; m_refh = d_ref;
      end
      m_err = !legal;
      base = restart ? 0 : m_acc;
      sum = base + m_fn;
      mmod = m_refh ? 1968 : 1920;
      carry = (sum >= mmod) ? 1 : 0;
      m_acc = carry ? sum - mmod : sum;
      p = m_narrow ? 6 : 8;
      exp_len = p * m_b + m_a + carry;
      exp_hi = (m_a + carry) * (p + 1);
      chk({req, " error flag"}, int'(cfg_err), int'(m_err));
   endtask

   // measure one division cycle starting at a pulse negedge
   task automatic run_cycle(input string req, input int chg_at);
      int n = 0;
      int hi = 0;
      do begin
         if (n == 1) chk("R8 pulse width", int'(fb_pulse), 0);
         if (n == chg_at) set_cfg(p_b, p_a, p_fn, p_psc, p_ref);
         if (mod_ctl) hi++;
         n++;
         @(negedge clk);
      end while (!fb_pulse);
      chk({req, " period"}, n, exp_len);
      chk({req, " R9 wide clocks"}, hi, exp_hi);
      mdl_boundary(req);
   endtask

   task automatic reset_and_default(input string req);
      int n = 0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk({req, " reset pulse low"}, int'(fb_pulse), 0);
      chk({req, " reset modctl low"}, int'(mod_ctl), 0);
      chk({req, " reset err low"}, int'(cfg_err), 0);
      rst = 1'b0;
      mdl_reset();
      do begin
         @(negedge clk);
         n++;
      end while (!fb_pulse);
      chk({req, " default period"}, n, 16);
      mdl_boundary(req);
   endtask

   task automatic t_reset();
      set_cfg(11, 4, 0, 0, 0);
      reset_and_default("R10");
   endtask

   task automatic t_integer();
      set_cfg(11, 4, 0, 0, 0);
      repeat (2) run_cycle("R1", -1);
      set_cfg(15, 7, 0, 0, 0);
      repeat (2) run_cycle("R1", -1);
   endtask

   task automatic t_fraction();
      set_cfg(11, 4, 1104, 0, 0);
      repeat (12) run_cycle("R3", -1);
   endtask

   task automatic t_full_swallow();
      set_cfg(8, 7, 1900, 0, 0);
      repeat (6) run_cycle("R9", -1);
   endtask

   task automatic t_ref_high();
      set_cfg(9, 3, 1404, 0, 1);
      repeat (8) run_cycle("R4", -1);
   endtask

   task automatic t_narrow();
      set_cfg(9, 5, 1164, 1, 0);
      repeat (6) run_cycle("R2", -1);
   endtask

   task automatic t_illegal();
      set_cfg(3, 3, 0, 0, 0);
      repeat (2) run_cycle("R5", -1);
      set_cfg(1, 0, 0, 0, 0);
      repeat (2) run_cycle("R6", -1);
      set_cfg(9, 2, 1930, 0, 0);
      repeat (2) run_cycle("R6", -1);
      set_cfg(9, 6, 0, 1, 0);
      repeat (2) run_cycle("R6", -1);
      set_cfg(9, 6, 0, 0, 0);
      repeat (2) run_cycle("R5", -1);
   endtask

   task automatic t_midcycle();
      set_cfg(10, 2, 500, 0, 0);
      run_cycle("R7", -1);
      p_b = 15; p_a = 1; p_fn = 700; p_psc = 1; p_ref = 1;
      run_cycle("R7", 5);
      repeat (3) run_cycle("R7", -1);
   endtask

   task automatic t_reset_again();
      set_cfg(11, 4, 1104, 0, 0);
      run_cycle("R10", -1);
      repeat (7) @(negedge clk);
      reset_and_default("R10");
      repeat (4) run_cycle("R10", -1);
   endtask

   initial begin
      t_reset();
      t_integer();
      t_fraction();
      t_full_swallow();
      t_ref_high();
      t_narrow();
      t_illegal();
      t_midcycle();
      t_reset_again();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #2000000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule